// File: doc/BRIEF.md
# Streaming Histogram Cell Array

The block builds a histogram of a pixel stream without any RAM. The bins are split into equal contiguous slices, and each slice belongs to one cell in a linear chain. Up to `LANES` pixels arrive per clock, each with its own valid bit. The samples ripple down the chain one cell per clock. Each cell adds to every bin it owns the number of lanes in that beat whose value equals the bin index. The counters are flip-flops inside the cells.

A controller sequences the frame with four states. `ST_IDLE` waits for `frame_start`, which zeroes every counter and moves to `ST_COMPUTE`. `ST_COMPUTE` accepts beats until a beat arrives with `frame_end` high, then moves to `ST_DRAIN`. `ST_DRAIN` waits until that last beat has passed the final cell, then moves to `ST_READ`. `ST_READ` shifts the counters toward the output, one bin per clock in ascending order, and returns to `ST_IDLE` after the last bin. Because the words come out in strict index order on consecutive cycles, an external memory can take them with a simple incrementing write address.

With a narrower stream, only the low lanes are driven. For example, one pixel per clock uses lane 0, and two pixels per clock use lanes 0 and 1.

Top module: `hist_array`

## Requirements
- R1: While reset is held, and after it until a frame is read out, `out_vld` and `out_last` are low.
- R2: Each readout gives the histogram of only the beats of its own frame. A bin's count is the number of accepted lanes whose pixel equals that bin index. Pixel lane l sits at bits `[l*PIX_W +: PIX_W]` of `in_pix`.
- R3: A lane is counted only when its bit in `in_vld` is high and the controller is in `ST_COMPUTE`. The beat carrying `frame_end` is included. Beats in `ST_IDLE`, on the `frame_start` cycle, or after `frame_end` are not counted.
- R4: When several lanes of one beat carry the same value, that bin grows by the number of such lanes, from 0 up to `LANES`.
- R5: A counter saturates at 2^CNT_W−1 and never wraps.
- R6: A readout is exactly 2^PIX_W words on consecutive cycles. `out_bin` starts at 0 and increases by one each word.
- R7: `out_last` is high only on the word with `out_bin` = 2^PIX_W−1, and `out_vld` is low on the cycle that follows it.
- R8: Let E be the clock edge that samples `frame_end`. The first readout word is valid after edge E+D, where D = max(N_CELLS−1, 1) and N_CELLS = 2^PIX_W / BINS_PER_CELL.
- R9: `frame_start` has no effect outside `ST_IDLE`. A pulse of it during `ST_COMPUTE` neither clears the counts nor restarts the frame.
- R10: `frame_end` has no effect outside `ST_COMPUTE`. A pulse of it in `ST_IDLE` produces no readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse in idle: clear counters, begin accepting beats |
| frame_end | input | 1 | Marks the last accepted beat of the frame |
| in_vld | input | LANES | Per-lane sample valid |
| in_pix | input | LANES*PIX_W | Packed lane pixels, lane 0 in the low bits |
| out_vld | output | 1 | Readout word valid |
| out_last | output | 1 | Readout word is the highest bin |
| out_bin | output | PIX_W | Bin index of the readout word |
| out_count | output | CNT_W | Count of that bin |

## Verification
The assertions check the shape of the readout stream on every cycle:
- a burst starts at bin 0;
- each word's index is one more than the previous one;
- `out_last` appears only on the top bin, and the stream stops right after it.

Only the bench's scenarios can show that the counts themselves are right, whether over random frames with one, two or four active lanes, with duplicate values in a beat, or with saturation. The scenarios also cover the exclusion of beats outside the frame, the readout latency after `frame_end`, and the harmless handling of frame controls in the wrong state.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPUTE = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_READ    = 2'd3
    } hist_state_t;
endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl #(
    parameter int PIX_W   = 6,
    parameter int N_CELLS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    output logic             clear,
    output logic             accept,
    output logic             count_en,
    output logic             shift_en,
    output logic             out_vld,
    output logic             out_last,
    output logic [PIX_W-1:0] out_bin
);
    import hist_pkg::*;

    localparam int N_BINS    = 2 ** PIX_W;
    localparam int DRAIN_LEN = (N_CELLS > 1) ? N_CELLS - 1 : 1;
    localparam int DRAIN_W   = $clog2(DRAIN_LEN + 1);

    hist_state_t        state, nxt;
    logic [DRAIN_W-1:0] drain_cnt;
    logic [PIX_W-1:0]   read_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (frame_start) nxt = ST_COMPUTE;
            ST_COMPUTE: if (frame_end)   nxt = ST_DRAIN;
            ST_DRAIN:   if (drain_cnt == DRAIN_W'(DRAIN_LEN - 1)) nxt = ST_READ;
            ST_READ:    if (read_idx == PIX_W'(N_BINS - 1))       nxt = ST_IDLE;
        endcase
    end

    // drain and read position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_cnt <= '0;
            read_idx  <= '0;
        end else begin
            drain_cnt <= (state == ST_DRAIN) ? drain_cnt + DRAIN_W'(1) : '0;
            read_idx  <= (state == ST_READ)  ? read_idx + PIX_W'(1)    : '0;
        end
    end

    // outputs
    always_comb begin
        clear    = 1'b0;
        accept   = 1'b0;
        count_en = 1'b0;
        shift_en = 1'b0;
        out_vld  = 1'b0;
        out_last = 1'b0;
        out_bin  = read_idx;
        unique case (state)
            ST_IDLE:    clear = frame_start;
            ST_COMPUTE: begin
                accept   = 1'b1;
                count_en = 1'b1;
            end
            ST_DRAIN:   count_en = 1'b1;
            ST_READ:    begin
                shift_en = 1'b1;
                out_vld  = 1'b1;
                out_last = (read_idx == PIX_W'(N_BINS - 1));
            end
        endcase
    end
endmodule

// File: rtl/hist_lane_stage.sv
module hist_lane_stage #(
    parameter int LANES = 4,
    parameter int PIX_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       vld_i,
    input  logic [LANES*PIX_W-1:0] pix_i,
    output logic [LANES-1:0]       vld_o,
    output logic [LANES*PIX_W-1:0] pix_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= '0;
            pix_o <= '0;
        end else begin
            vld_o <= vld_i;
            pix_o <= pix_i;
        end
    end
endmodule

// File: rtl/hist_cell.sv
module hist_cell #(
    parameter int CELL_IDX      = 0,
    parameter int LANES         = 4,
    parameter int PIX_W         = 6,
    parameter int BINS_PER_CELL = 4,
    parameter int CNT_W         = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   count_en,
    input  logic                   shift_en,
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES*PIX_W-1:0] lane_pix,
    input  logic [CNT_W-1:0]       shift_in,
    output logic [CNT_W-1:0]       shift_out
);
    localparam int INC_W = $clog2(LANES + 1);
    localparam int SUM_W = CNT_W + INC_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] bin_q [BINS_PER_CELL];

    for (genvar b = 0; b < BINS_PER_CELL; b++) begin : g_bin
        localparam int BIN_ID = CELL_IDX * BINS_PER_CELL + b;
        logic [INC_W-1:0] inc;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] sat;
        logic [CNT_W-1:0] shift_src;

        if (b == BINS_PER_CELL - 1) begin : g_tail
            assign shift_src = shift_in;
        end else begin : g_mid
            assign shift_src = bin_q[b+1];
        end

        always_comb begin
            inc = '0;
            for (int l = 0; l < LANES; l++) begin
                if (lane_vld[l] && lane_pix[l*PIX_W +: PIX_W] == PIX_W'(BIN_ID))
                    inc = inc + INC_W'(1);
            end
            sum = SUM_W'(bin_q[b]) + SUM_W'(inc);
            sat = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clear) bin_q[b] <= '0;
            else if (shift_en)   bin_q[b] <= shift_src;
            else if (count_en)   bin_q[b] <= sat;
        end
    end

    assign shift_out = bin_q[0];
endmodule

// File: rtl/hist_array.sv
module hist_array #(
    parameter int LANES         = 4,
    parameter int PIX_W         = 6,
    parameter int BINS_PER_CELL = 4,
    parameter int CNT_W         = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   frame_end,
    input  logic [LANES-1:0]       in_vld,
    input  logic [LANES*PIX_W-1:0] in_pix,
    output logic                   out_vld,
    output logic                   out_last,
    output logic [PIX_W-1:0]       out_bin,
    output logic [CNT_W-1:0]       out_count
);
    localparam int N_BINS  = 2 ** PIX_W;
    localparam int N_CELLS = N_BINS / BINS_PER_CELL;

    logic clear, accept, count_en, shift_en;

    logic [LANES-1:0]       stage_vld [N_CELLS];
    logic [LANES*PIX_W-1:0] stage_pix [N_CELLS];
    logic [CNT_W-1:0]       cnt_link  [N_CELLS+1];

    hist_ctrl #(.PIX_W(PIX_W), .N_CELLS(N_CELLS)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .clear(clear), .accept(accept), .count_en(count_en), .shift_en(shift_en),
        .out_vld(out_vld), .out_last(out_last), .out_bin(out_bin)
    );

    assign stage_vld[0]      = in_vld & {LANES{accept}};
    assign stage_pix[0]      = in_pix;
    assign cnt_link[N_CELLS] = '0;
    assign out_count         = cnt_link[0];

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        hist_cell #(
            .CELL_IDX(c), .LANES(LANES), .PIX_W(PIX_W),
            .BINS_PER_CELL(BINS_PER_CELL), .CNT_W(CNT_W)
        ) cell_i (
            .clk(clk), .rst_n(rst_n), .clear(clear),
            .count_en(count_en), .shift_en(shift_en),
            .lane_vld(stage_vld[c]), .lane_pix(stage_pix[c]),
            .shift_in(cnt_link[c+1]), .shift_out(cnt_link[c])
        );

        if (c < N_CELLS - 1) begin : g_stage
            hist_lane_stage #(.LANES(LANES), .PIX_W(PIX_W)) stage_i (
                .clk(clk), .rst_n(rst_n),
                .vld_i(stage_vld[c]), .pix_i(stage_pix[c]),
                .vld_o(stage_vld[c+1]), .pix_o(stage_pix[c+1])
            );
        end
    end
endmodule

// File: rtl/hist_array_chk.sv
module hist_array_chk #(
    parameter int PIX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_vld,
    input logic             out_last,
    input logic [PIX_W-1:0] out_bin
);
    localparam int N_BINS = 2 ** PIX_W;

    a_r6_burst_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> out_bin == '0);

    a_r6_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_last) |=> (out_vld && out_bin == $past(out_bin) + PIX_W'(1)));

    a_r6_burst_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_vld) |-> $past(out_last));

    a_r7_last_on_top_bin: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_vld && out_bin == PIX_W'(N_BINS - 1)));

    a_r7_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_vld);
endmodule

bind hist_array hist_array_chk #(.PIX_W(PIX_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .out_vld(out_vld), .out_last(out_last), .out_bin(out_bin)
);

// File: tb/hist_array_tb_top.sv
module hist_array_tb_top;
    localparam int LANES   = 4;
    localparam int PIX_W   = 5;
    localparam int BPC     = 4;
    localparam int CNT_W   = 6;
    localparam int N_BINS  = 2 ** PIX_W;
    localparam int N_CELLS = N_BINS / BPC;
    localparam int DRAIN   = (N_CELLS > 1) ? N_CELLS - 1 : 1;
    localparam int CMAX    = 2 ** CNT_W - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   frame_start = 1'b0;
    logic                   frame_end = 1'b0;
    logic [LANES-1:0]       in_vld = '0;
    logic [LANES*PIX_W-1:0] in_pix = '0;
    logic                   out_vld, out_last;
    logic [PIX_W-1:0]       out_bin;
    logic [CNT_W-1:0]       out_count;

    always #10 clk = ~clk;

    hist_array #(.LANES(LANES), .PIX_W(PIX_W), .BINS_PER_CELL(BPC), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .in_vld(in_vld), .in_pix(in_pix),
        .out_vld(out_vld), .out_last(out_last), .out_bin(out_bin), .out_count(out_count)
    );

    typedef struct {
        int    bin;
        int    cnt;
        bit    last;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    model [N_BINS];
    int    checks = 0, errors = 0, spurious = 0, cyc = 0, fe_cyc = 0;
    bit    first_pending = 1'b0, reported = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: pops expected words as the design emits them
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_vld) begin
                if (q.size() == 0) begin
                    spurious++;
                    chk(1'b0, "R10", "unexpected readout word bin", int'(out_bin), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (first_pending) begin
                        chk(cyc - fe_cyc == DRAIN, "R8", "latency to first word", cyc - fe_cyc, DRAIN);
                        first_pending = 1'b0;
                    end
                    chk(int'(out_bin) == e.bin, "R6", "bin index", int'(out_bin), e.bin);
                    chk(int'(out_count) == e.cnt, e.tag, $sformatf("count of bin %0d", e.bin),
                        int'(out_count), e.cnt);
                    chk(out_last == e.last, "R7", $sformatf("last flag at bin %0d", e.bin),
                        int'(out_last), int'(e.last));
                end
            end
        end
    end

    task automatic start_frame();
        for (int b = 0; b < N_BINS; b++) model[b] = 0;
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic beat(input logic [LANES-1:0] v, input int p0, input int p1, input int p2,
                        input int p3, input bit fe, input bit counted);
        int p [LANES];
        p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
        in_vld    = v;
        frame_end = fe;
        for (int l = 0; l < LANES; l++) begin
            in_pix[l*PIX_W +: PIX_W] = PIX_W'(p[l]);
            if (counted && v[l]) model[p[l]]++;
        end
        @(posedge clk); #1;
        if (fe && counted) begin
            fe_cyc        = cyc;
            first_pending = 1'b1;
        end
        in_vld    = '0;
        frame_end = 1'b0;
    endtask

    // driver side of the scoreboard: push the expected readout, wait for it
    task automatic finish_frame(input string tag);
        for (int b = 0; b < N_BINS; b++) begin
            exp_t e;
            e.bin  = b;
            e.cnt  = (model[b] > CMAX) ? CMAX : model[b];
            e.last = (b == N_BINS - 1);
            e.tag  = tag;
            q.push_back(e);
        end
        while (q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic rand_frame(input logic [LANES-1:0] mask, input bit rand_mask, input int n,
                              input string tag);
        start_frame();
        for (int i = 0; i < n; i++) begin
            logic [LANES-1:0] m;
            m = rand_mask ? LANES'($urandom % 16) : mask;
            beat(m, $urandom % N_BINS, $urandom % N_BINS, $urandom % N_BINS,
                 $urandom % N_BINS, i == n - 1, 1'b1);
        end
        finish_frame(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        int s0;
        // R1: outputs quiet in and after reset
        repeat (3) @(posedge clk);
        #1;
        chk(out_vld == 1'b0 && out_last == 1'b0, "R1", "out_vld during reset", int'(out_vld), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(out_vld == 1'b0, "R1", "out_vld after reset", int'(out_vld), 0);

        // R3: beat in idle is ignored, then one-lane frame
        beat(4'b1111, 3, 3, 3, 3, 1'b0, 1'b0);
        rand_frame(4'b0001, 1'b0, 40, "R3");
        // two lanes and four lanes per clock
        rand_frame(4'b0011, 1'b0, 40, "R2");
        rand_frame(4'b1111, 1'b0, 30, "R2");
        rand_frame(4'b0000, 1'b1, 40, "R3");

        // R4: duplicates inside one beat
        start_frame();
        for (int i = 0; i < 5; i++) beat(4'b1111, 9, 9, 9, 9, 1'b0, 1'b1);
        beat(4'b1011, 17, 17, 2, 17, 1'b0, 1'b1);
        beat(4'b0110, 0, 31, 31, 5, 1'b1, 1'b1);
        finish_frame("R4");

        // R5: saturation of top and bottom bins, near-limit count
        start_frame();
        for (int i = 0; i < 20; i++) beat(4'b1111, 31, 31, 31, 31, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) beat(4'b1111, 0, 0, 0, 0, 1'b0, 1'b1);
        for (int i = 0; i < 15; i++) beat(4'b1111, 12, 12, 12, 12, 1'b0, 1'b1);
        beat(4'b0111, 12, 12, 12, 1, 1'b1, 1'b1);
        finish_frame("R5");

        // R9: frame_start inside a frame does not clear; R3: beats after frame_end ignored
        start_frame();
        for (int i = 0; i < 6; i++) beat(4'b1111, i, i + 1, 20, 20, 1'b0, 1'b1);
        frame_start = 1'b1;
        beat(4'b0011, 7, 8, 0, 0, 1'b0, 1'b1);
        frame_start = 1'b0;
        for (int i = 0; i < 6; i++) beat(4'b1111, 20, 21, 22, 23, i == 5, 1'b1);
        for (int i = 0; i < 3; i++) beat(4'b1111, 4, 4, 4, 4, 1'b0, 1'b0);
        finish_frame("R9");

        // R10: frame_end in idle gives no readout
        s0 = spurious;
        beat(4'b1111, 1, 2, 3, 4, 1'b1, 1'b0);
        repeat (N_BINS + 20) @(posedge clk);
        #1;
        chk(spurious == s0, "R10", "words after idle frame_end", spurious - s0, 0);
        chk(out_vld == 1'b0, "R10", "out_vld in idle", int'(out_vld), 0);

        // R2: back-to-back frames keep separate histograms
        rand_frame(4'b1111, 1'b0, 25, "R2");
        rand_frame(4'b0011, 1'b0, 10, "R2");

        report();
    end
endmodule